// File: doc/BRIEF.md
# RMII Receive Nibble Adapter

This block sits on the MAC side of a reduced media-independent receive link. Everything runs on one 50 MHz reference clock, and that clock serves transmit and receive alike. Each clock the block sees a 2-bit receive data pair, a single line that carries both carrier sense and data valid, a receive error line and the local transmit enable. From these it rebuilds the 4-bit nibble stream, with a one-cycle strobe for each nibble, that a nibble-oriented MAC core expects.

The shared line has to be split into two signals. Recovered carrier drops at the first low sample of the line. This low sample is the end-of-frame toggle. Data valid stays high until the line has been low for a full nibble period. The link has no collision pin, so the block computes collision from recovered carrier and transmit enable. A receive error seen inside a frame sets a latched flag. In the slow rate each dibit is held for ten reference cycles. A divider takes one sample per ten cycles, and it is aligned to the cycle in which the line first rises.

Top module: `rmii_rx_adapter`

## Requirements
- R1: While reset is low, and in the first cycle after reset is released, every output reads 0.
- R2: A "sample" is taken every clock when `speed_10_i`=0. When `speed_10_i`=1, a sample is taken on the clock in which `crs_dv_i` first goes high from idle, and then once every 10 clocks while the frame is active.
- R3: Nibbles are built from sampled pairs. The first pair goes to bits [1:0] and the second pair to bits [3:2]. `nib_vld_o` is high for exactly one cycle, the cycle after the sample of the second pair, and `nib_o` holds the nibble in that cycle.
- R4: After the line rises, pairs equal to 00 are dropped until the first pair equal to 01. That 01 pair becomes bits [1:0] of the first nibble.
- R5: `crs_o` rises the cycle after a high sample taken while the block is idle. It falls the cycle after the first low sample. It does not rise again until `dv_o` has fallen.
- R6: `dv_o` rises together with `crs_o`. It falls the cycle after the second consecutive low sample, and a half-built nibble is then discarded. A single low sample followed by a high one does not end the frame.
- R7: `col_o` in cycle t+1 equals recovered carrier at t+1 AND `tx_en_i` at cycle t.
- R8: At the 100 Mb/s rate (`speed_10_i`=0), a sample with `rx_er_i`=1 while data valid is high sets `rx_err_o` from the next cycle. The flag stays set until the cycle in which `dv_o` falls, and then it clears.
- R9: At the 10 Mb/s rate, `rx_er_i` has no effect, and `rx_err_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_10_i | input | 1 | 1 = 10 Mb/s rate, 0 = 100 Mb/s rate |
| crs_dv_i | input | 1 | Shared carrier-sense / data-valid line |
| rxd_i | input | 2 | Receive data pair |
| rx_er_i | input | 1 | Receive error from the PHY |
| tx_en_i | input | 1 | Local transmit enable |
| nib_o | output | 4 | Assembled receive nibble |
| nib_vld_o | output | 1 | One-cycle strobe for `nib_o` |
| crs_o | output | 1 | Recovered carrier sense |
| dv_o | output | 1 | Recovered receive data valid |
| col_o | output | 1 | Locally derived collision |
| rx_err_o | output | 1 | Latched in-frame receive error |

## Verification
Some relations are checked by assertions on every cycle:
- Carrier never stands without data valid.
- Carrier rises only from idle.
- Data valid falls only after a low sample.
- Nibble strobes are isolated single pulses inside a frame.
- Collision implies both carrier and the previous transmit enable.
- The error flag is confined to valid data and stays quiet at the slow rate.

Other properties can only be shown by the bench's frame scenarios:
- Pairs land in the right nibble halves.
- The leading zeros are skipped.
- The end-of-frame toggle does not cut off data.
- The ten-cycle sampling phase is right.

These scenarios compare against a behavioural model at both rates, with odd and even numbers of leading zeros.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;
    parameter int PAIR_W     = 2;
    parameter int NIBBLE_W   = 4;
    parameter int SLOW_RATIO = 10;
    localparam int PAIRS_PER_NIB = NIBBLE_W / PAIR_W;

    typedef logic [PAIR_W-1:0]   pair_t;
    typedef logic [NIBBLE_W-1:0] nibble_t;

    localparam pair_t START_PAIR = pair_t'(1);
endpackage

// File: rtl/rmii_rx_pacer.sv
module rmii_rx_pacer #(
    parameter int SLOW_DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_i,
    input  logic active_i,
    output logic smp_o
);
    localparam int CW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pace_t;

    pace_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!active_i || !slow_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == CW'(SLOW_DIV - 1)) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign smp_o = !slow_i || (st_q.cnt == '0);

    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < CW'(SLOW_DIV)); // R2
    AST_IDLE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(active_i) |-> st_q.cnt == '0); // R2
endmodule

// File: rtl/rmii_rx_split.sv
module rmii_rx_split #(
    parameter int LOW_RUN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_i,
    input  logic line_i,
    output logic crs_o,
    output logic crs_next_o,
    output logic dv_o,
    output logic dv_next_o
);
    localparam int LW = $clog2(LOW_RUN + 1);

    typedef struct packed {
        logic          crs;
        logic          dv;
        logic [LW-1:0] lows;
    } split_t;

    split_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (smp_i) begin
            if (line_i) begin
                st_d.lows = '0;
                st_d.dv   = 1'b1;
                st_d.crs  = st_q.crs | !st_q.dv;
            end else begin
                st_d.crs = 1'b0;
                if (!st_q.dv) begin
                    st_d.lows = '0;
                end else if (st_q.lows == LW'(LOW_RUN - 1)) begin
                    st_d.dv   = 1'b0;
                    st_d.lows = '0;
                end else begin
                    st_d.lows = st_q.lows + LW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign crs_o      = st_q.crs;
    assign dv_o       = st_q.dv;
    assign crs_next_o = st_d.crs;
    assign dv_next_o  = st_d.dv;

    AST_CRS_NEEDS_DV: assert property (@(posedge clk) disable iff (!rst_n)
        crs_o |-> dv_o); // R5
    AST_CRS_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crs_o) |-> !$past(dv_o)); // R5
    AST_DV_FALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dv_o) |-> !$past(line_i) && $past(smp_i)); // R6
endmodule

// File: rtl/rmii_rx_nib_asm.sv
module rmii_rx_nib_asm
    import rmii_rx_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    smp_i,
    input  logic    dv_next_i,
    input  pair_t   pair_i,
    output nibble_t nib_o,
    output logic    vld_o
);
    localparam int CNT_W = (PAIRS_PER_NIB > 2) ? $clog2(PAIRS_PER_NIB) : 1;

    typedef struct packed {
        logic             started;
        logic [CNT_W-1:0] cnt;
        nibble_t          acc;
        nibble_t          nib;
        logic             vld;
    } asm_t;

    asm_t    st_d, st_q;
    nibble_t shifted;

    always_comb begin
        shifted = {pair_i, st_q.acc[NIBBLE_W-1:PAIR_W]};
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (smp_i) begin
            if (!dv_next_i) begin
                st_d.started = 1'b0;
                st_d.cnt     = '0;
            end else if (!st_q.started) begin
                if (pair_i == START_PAIR) begin
                    st_d.started = 1'b1;
                    st_d.acc     = shifted;
                    st_d.cnt     = CNT_W'(1);
                end
            end else if (st_q.cnt == CNT_W'(PAIRS_PER_NIB - 1)) begin
                st_d.nib = shifted;
                st_d.vld = 1'b1;
                st_d.acc = shifted;
                st_d.cnt = '0;
            end else begin
                st_d.acc = shifted;
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign nib_o = st_q.nib;
    assign vld_o = st_q.vld;

    AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |=> !vld_o); // R3
    AST_VLD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> $past(dv_next_i) && $past(smp_i)); // R3
endmodule

// File: rtl/rmii_rx_adapter.sv
module rmii_rx_adapter
    import rmii_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       speed_10_i,
    input  logic       crs_dv_i,
    input  logic [1:0] rxd_i,
    input  logic       rx_er_i,
    input  logic       tx_en_i,
    output logic [3:0] nib_o,
    output logic       nib_vld_o,
    output logic       crs_o,
    output logic       dv_o,
    output logic       col_o,
    output logic       rx_err_o
);
    typedef struct packed {
        logic col;
        logic err;
    } top_t;

    top_t st_d, st_q;
    logic smp, crs_next, dv_next;

    rmii_rx_pacer #(.SLOW_DIV(SLOW_RATIO)) u_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .slow_i   (speed_10_i),
        .active_i (dv_o | crs_dv_i),
        .smp_o    (smp)
    );

    rmii_rx_split #(.LOW_RUN(PAIRS_PER_NIB)) u_split (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_i      (smp),
        .line_i     (crs_dv_i),
        .crs_o      (crs_o),
        .crs_next_o (crs_next),
        .dv_o       (dv_o),
        .dv_next_o  (dv_next)
    );

    rmii_rx_nib_asm u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_i     (smp),
        .dv_next_i (dv_next),
        .pair_i    (rxd_i),
        .nib_o     (nib_o),
        .vld_o     (nib_vld_o)
    );

    always_comb begin
        st_d     = st_q;
        st_d.col = crs_next & tx_en_i;
        if (!dv_next) begin
            st_d.err = 1'b0;
        end else if (smp && rx_er_i && !speed_10_i) begin
            st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign col_o    = st_q.col;
    assign rx_err_o = st_q.err;

    AST_COL_NEEDS_CRS: assert property (@(posedge clk) disable iff (!rst_n)
        col_o |-> crs_o); // R7
    AST_COL_NEEDS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        col_o |-> $past(tx_en_i)); // R7
    AST_ERR_NEEDS_DV: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err_o |-> dv_o); // R8
    AST_ERR_SLOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        speed_10_i && $past(speed_10_i) && !$past(rx_err_o) |-> !rx_err_o); // R9
endmodule

// File: tb/rmii_rx_adapter_bench.sv
`timescale 1ns/1ps
module rmii_rx_adapter_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spd = 1'b0, line = 1'b0, er = 1'b0, tx = 1'b0;
    logic [1:0] rxd = 2'b00;
    logic [3:0] nib;
    logic vld, crs, dv, col, err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rmii_rx_adapter u_rmii_rx_adapter (
        .clk(clk), .rst_n(rst_n), .speed_10_i(spd), .crs_dv_i(line),
        .rxd_i(rxd), .rx_er_i(er), .tx_en_i(tx), .nib_o(nib),
        .nib_vld_o(vld), .crs_o(crs), .dv_o(dv), .col_o(col), .rx_err_o(err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int  m_div = 0, m_low = 0, m_cnt = 0;
    bit  m_dv = 0, m_crs = 0, m_run = 0, m_vld = 0, m_err = 0, m_col = 0;
    int  m_first = 0, m_nib = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_div = 0; m_low = 0; m_cnt = 0; m_dv = 0; m_crs = 0;
            m_run = 0; m_vld = 0; m_err = 0; m_col = 0; m_nib = 0; m_first = 0;
        end else begin
            bit take, ndv, ncrs, act;
            take = !spd || (m_div == 0);
            act  = m_dv || line;
            ndv = m_dv; ncrs = m_crs;
            if (take) begin
                if (line) begin
                    ncrs = m_crs || !m_dv; ndv = 1; m_low = 0;
                end else begin
                    ncrs = 0;
                    if (m_dv) begin
                        m_low++;
                        if (m_low >= 2) begin ndv = 0; m_low = 0; end
                    end else m_low = 0;
                end
            end
            m_vld = 0;
            if (take) begin
                if (!ndv) begin m_run = 0; m_cnt = 0; end
                else if (!m_run) begin
                    if (rxd == 2'b01) begin m_run = 1; m_first = 1; m_cnt = 1; end
                end else if (m_cnt == 1) begin
                    m_nib = rxd * 4 + m_first; m_vld = 1; m_cnt = 0;
                end else begin
                    m_first = rxd; m_cnt = 1;
                end
            end
            if (!ndv) m_err = 0;
            else if (take && er && !spd) m_err = 1;
            m_col = ncrs && tx;
            m_div = (!act || !spd) ? 0 : (m_div + 1) % 10;
            m_dv = ndv; m_crs = ncrs;
        end
    end

    bit cmp_on = 1'b0;
    always @(negedge clk) begin
        if (cmp_on && !finished) begin
            chk(vld === m_vld, "R3 strobe (R2 pacing)", vld, m_vld);
            if (m_vld) chk(nib === 4'(m_nib), "R3 nibble value", nib, m_nib);
            chk(crs === m_crs, "R5 carrier", crs, m_crs);
            chk(dv === m_dv, "R6 data valid", dv, m_dv);
            chk(col === m_col, "R7 collision", col, m_col);
            chk(err === m_err, "R8 error flag", err, m_err);
        end
    end

    // directed capture
    int  got_q[$];
    bit  saw_err = 0, saw_col = 0;
    always @(negedge clk) begin
        if (rst_n && vld) got_q.push_back(int'(nib));
        if (rst_n && err) saw_err = 1;
        if (rst_n && col) saw_col = 1;
    end

    task automatic put(input bit c, input logic [1:0] d, input bit e, input bit t);
        repeat (spd ? 10 : 1) begin
            @(negedge clk); #1;
            line = c; rxd = d; er = e; tx = t;
        end
    endtask

    task automatic send_frame(input bit slow, input int zeros, input int nbytes,
                              input int seed, input bit er_mid, input bit tx_mid);
        int pairs[$];
        int exp_q[$];
        spd = slow;
        got_q.delete(); saw_err = 0; saw_col = 0;
        repeat (3) put(0, 2'b00, 0, 0);
        for (int i = 0; i < zeros; i++) put(1, 2'b00, 0, 0);
        for (int i = 0; i < 7; i++) begin put(1, 2'b01, 0, 0); pairs.push_back(1); end
        put(1, 2'b11, 0, 0); pairs.push_back(3);
        for (int b = 0; b < nbytes; b++) begin
            int v;
            v = (seed + b * 37) & 255;
            for (int k = 0; k < 4; k++) begin
                bit c, e, t;
                logic [1:0] d;
                d = 2'((v >> (2 * k)) & 3);
                c = (b >= nbytes - 2) ? ((k % 2) == 1) : 1'b1;
                e = er_mid && (b == 1) && (k == 0);
                t = tx_mid && (b < 3);
                put(c, d, e, t);
                pairs.push_back(int'(d));
            end
        end
        repeat (4) put(0, 2'b00, 0, 0);
        for (int i = 0; i + 1 < pairs.size(); i += 2)
            exp_q.push_back(pairs[i + 1] * 4 + pairs[i]);
        chk(got_q.size() == exp_q.size(), "R4 nibble count", got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            chk(got_q[i] == exp_q[i], "R3 nibble order", got_q[i], exp_q[i]);
        chk(saw_err == (er_mid && !slow), slow ? "R9 slow error ignored" : "R8 error latched",
            saw_err, er_mid && !slow);
        chk(saw_col == tx_mid, "R7 collision seen", saw_col, tx_mid);
        chk(err == 1'b0 && dv == 1'b0, "R8 flag cleared after frame", err, 0);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk({nib, vld, crs, dv, col, err} == 9'd0, "R1 outputs in reset", 0, 0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk({nib, vld, crs, dv, col, err} == 9'd0, "R1 outputs after reset", 0, 0);
        cmp_on = 1'b1;
        send_frame(0, 3, 6, 17, 0, 0);
        send_frame(0, 2, 5, 200, 1, 1);
        send_frame(1, 1, 4, 90, 1, 1);
        send_frame(1, 4, 3, 5, 0, 0);
        send_frame(0, 0, 4, 251, 0, 1);
        // single low sample mid-frame must not end it (R6)
        spd = 0;
        put(1, 2'b01, 0, 0); put(0, 2'b10, 0, 0);
        @(negedge clk);
        chk(dv == 1'b1 && crs == 1'b0, "R6 one low sample keeps dv", dv, 1);
        put(1, 2'b11, 0, 0);
        repeat (4) put(0, 2'b00, 0, 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule